// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Register and Status Flags

This block receives 8-bit characters from an asynchronous serial line. An external divider supplies a one-cycle `os_tick` pulse at sixteen times the bit rate. Each character is framed by a low start bit and a high stop bit, with the data bits sent least-significant bit first. The line passes through a two-stage synchronizer, and a frame engine uses the oversampling ticks to place a sample near the middle of each bit.

When the stop bit has been sampled, the assembled character moves into a single holding register together with its error flags. Software reaches the block through a small register bus with a 2-bit address and separate read and write strobes:

- Address 0 is the received character.
- Address 1 is the status byte.
- Address 2 is the control byte, whose bit 0 enables the interrupt.

`rdata` follows `addr` combinationally. A read takes effect at the clock edge where `rd_en` is high. No data moves through a valid/ready stream. Back-pressure is carried by the receive-complete flag: while it is set, the holding register is full, and further characters are dropped and recorded as overrun.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the status byte (address 1) reads 0x00 and `irq` is low.
- R2: A frame of one low start bit, eight data bits LSB first and a stop bit, each lasting 16 ticks of `os_tick`, delivers its eight data bits at address 0.
- R3: Status bit 7 (receive complete) sets when a character enters the holding register, including a character whose stop bit was low.
- R4: Receive complete clears only when address 0 is read. Reading the status byte leaves it set.
- R5: `irq` is high exactly while control bit 0 (address 2) is 1 and receive complete is set. It stays high until address 0 is read.
- R6: Status bit 4 (framing error) is 1 when the stored character's stop bit sampled low. It returns to 0 when a later stored character has a high stop bit.
- R7: If a character completes while receive complete is set, that character is discarded and status bit 3 (overrun) sets. The held character is unchanged, and a read of address 0 clears overrun.
- R8: A low on the line that is no longer low at the eighth tick is treated as noise. The receiver returns to idle and stores nothing.
- R9: Status bits 6, 5, 2, 1 and 0 read as 0. Writes to addresses 0 and 1 change neither the character nor the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Read strobe; a read of address 0 clears receive complete and overrun |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address: 0 character, 1 status, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume the following about the inputs:

- `os_tick` is a single-cycle pulse.
- A read of address 0 never lands in the same cycle that a frame completes, so every clear of receive complete can be traced to a read.
- Every bit lasts exactly sixteen ticks.

The stimulus meets these conditions. It issues a tick every fourth clock and holds each bit for 64 clocks. It reads only after the line has been idle for a full bit time, and after each frame it waits long enough that no frame is still in progress when it reads. When it sends a framing-error character, it releases the low stop bit just after its midpoint. The receiver therefore sees the tail only as a short false start and rejects it.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_CHAR = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int STAT_RXC = 7;
  localparam int STAT_FE  = 4;
  localparam int STAT_OVR = 3;
  localparam int CTRL_IE  = 0;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rxs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  output logic              done,
  output logic [DATA_W-1:0] char_out,
  output logic              stop_ok
);
  localparam int CW  = $clog2(OS_RATE);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OS_RATE / 2;

  rx_state_e         state;
  logic [CW-1:0]     os_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      os_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!rx) begin
              state  <= ST_START;
              os_cnt <= CW'(1);
            end
          end
          ST_START: begin
            if (os_cnt == CW'(MID - 1)) begin
              os_cnt  <= '0;
              bit_cnt <= '0;
              state   <= rx ? ST_IDLE : ST_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (os_cnt == CW'(OS_RATE - 1)) begin
              os_cnt <= '0;
              shreg  <= {rx, shreg[DATA_W-1:1]};
              if (bit_cnt == BW'(DATA_W - 1)) state <= ST_STOP;
              else bit_cnt <= bit_cnt + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          default: begin
            if (os_cnt == CW'(OS_RATE - 1)) begin
              os_cnt  <= '0;
              done    <= 1'b1;
              stop_ok <= rx;
              state   <= ST_IDLE;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign char_out = shreg;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (int'(bit_cnt) < DATA_W));

  // R8
  start_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && $past(state) != ST_START) |-> !$past(done));
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] char_in,
  input  logic              stop_ok,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  logic [DATA_W-1:0] char_q;
  logic              rxc_q, fe_q, ovr_q, ie_q;
  logic              clr;

  assign clr = rd_en && (addr == ADDR_CHAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      rxc_q  <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (clr) begin
        rxc_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (done) begin
        if (rxc_q && !clr) begin
          ovr_q <= 1'b1;
        end else begin
          char_q <= char_in;
          fe_q   <= !stop_ok;
          rxc_q  <= 1'b1;
          ovr_q  <= 1'b0;
        end
      end
      if (wr_en && addr == ADDR_CTRL) ie_q <= wdata[CTRL_IE];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CHAR: rdata = BUS_W'(char_q);
      ADDR_STAT: begin
        rdata[STAT_RXC] = rxc_q;
        rdata[STAT_FE]  = fe_q;
        rdata[STAT_OVR] = ovr_q;
      end
      ADDR_CTRL: rdata[CTRL_IE] = ie_q;
      default:   rdata = '0;
    endcase
  end

  assign irq = ie_q & rxc_q;

  // R3
  rxc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxc_q) |-> $past(done));

  // R4
  rxc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxc_q) |-> $past(clr));

  // R7
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rxc_q));

  // R7
  held_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxc_q && !clr) |=> $stable(char_q));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  logic              rx_s;
  logic              f_done, f_stop;
  logic [DATA_W-1:0] f_char;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
    .done(f_done), .char_out(f_char), .stop_ok(f_stop)
  );

  rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(f_done), .char_in(f_char),
    .stop_ok(f_stop), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [1:0] tdiv;

  always #2.5 clk = ~clk;

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv <= 2'd0;
      os_tick <= 1'b0;
    end else begin
      tdiv <= tdiv + 2'd1;
      os_tick <= (tdiv == 2'd3);
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (64) @(negedge clk);
    end
    rxd = stop;
    repeat (stop ? 64 : 44) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(2'd1, v);
    chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_patterns;
    logic [7:0] v;
    logic [7:0] pats [4] = '{8'hA5, 8'h00, 8'hFF, 8'h01};
    foreach (pats[k]) begin
      send_frame(pats[k], 1'b1);
      bus_read(2'd1, v);
      chk("R3 rxc set, R9 unused bits zero", v, 8'h80);
      bus_read(2'd0, v);
      chk("R2 received character", v, pats[k]);
      bus_read(2'd1, v);
      chk("R4 rxc cleared by data read", v, 8'h00);
    end
  endtask

  task automatic t_status_read_keeps;
    logic [7:0] v;
    send_frame(8'h6E, 1'b1);
    bus_read(2'd1, v);
    bus_read(2'd1, v);
    chk("R4 status read leaves rxc", v, 8'h80);
    bus_read(2'd0, v);
    chk("R2 character 6E", v, 8'h6E);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send_frame(8'h55, 1'b0);
    bus_read(2'd1, v);
    chk("R6 R3 framing error with rxc", v, 8'h90);
    bus_read(2'd0, v);
    chk("R2 char with bad stop", v, 8'h55);
    send_frame(8'h0F, 1'b1);
    bus_read(2'd1, v);
    chk("R6 framing error cleared by good stop", v, 8'h80);
    bus_read(2'd0, v);
    chk("R2 char 0F", v, 8'h0F);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send_frame(8'h12, 1'b1);
    send_frame(8'h34, 1'b1);
    bus_read(2'd1, v);
    chk("R7 overrun flag", v, 8'h88);
    bus_read(2'd0, v);
    chk("R7 first char kept", v, 8'h12);
    bus_read(2'd1, v);
    chk("R7 overrun cleared by read", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    send_frame(8'h77, 1'b1);
    chk("R5 irq low with enable off", {7'd0, irq}, 8'h00);
    bus_write(2'd2, 8'h01);
    @(negedge clk);
    chk("R5 irq high once enabled", {7'd0, irq}, 8'h01);
    bus_read(2'd1, v);
    @(negedge clk);
    chk("R5 irq held after status read", {7'd0, irq}, 8'h01);
    bus_read(2'd0, v);
    @(negedge clk);
    chk("R5 irq low after data read", {7'd0, irq}, 8'h00);
    send_frame(8'h99, 1'b1);
    chk("R5 irq with new char", {7'd0, irq}, 8'h01);
    bus_read(2'd0, v);
    bus_write(2'd2, 8'h00);
  endtask

  task automatic t_false_start;
    logic [7:0] v;
    @(negedge clk);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    bus_read(2'd1, v);
    chk("R8 glitch stores nothing", v, 8'h00);
    send_frame(8'h3C, 1'b1);
    bus_read(2'd0, v);
    chk("R8 frame after glitch", v, 8'h3C);
  endtask

  task automatic t_writes_ignored;
    logic [7:0] v;
    send_frame(8'h5A, 1'b1);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v);
    chk("R9 status unchanged by writes", v, 8'h80);
    bus_read(2'd0, v);
    chk("R9 char unchanged by write", v, 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_patterns();
    t_status_read_keeps();
    t_framing();
    t_overrun();
    t_irq();
    t_false_start();
    t_writes_ignored();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule